// File: doc/BRIEF.md
# Reset Source Capture Controller

This block merges every reset request in the chip into one system reset and keeps a byte-wide cause register that tells software which source produced the most recent reset. Power-on is asynchronous and resets the whole block. All other requests are sampled on the clock. These are the external reset pin, a supply-monitor trip, a lost-clock event, a watchdog expiry, a comparator output that is active low, a flash access error, and a software trigger. Any request starts the system reset, or keeps it asserted, and the output stays high for a fixed stretch after the last request goes away.

The cause register sits on a simple special-function-register bus at address 0xEF. Some bits mean one thing on a read and another on a write. A read returns the latched cause flags. A write to the same positions sets the source enables for the comparator, the clock detector and the supply monitor, or fires a software reset. Software must therefore write whole values and never use read-modify-write. The enables survive every reset except power-on.

Top module: `rst_cause_ctrl`

## Requirements
- R1: While power-on is asserted and after it is released, the system reset is high. The register reads 0x02, the supply-monitor enable is 1, and the clock-detector and comparator enables are 0, so a low comparator output causes no reset.
- R2: The system reset stays high for exactly 16 clock edges after the last edge at which any request was sampled active. It is low after that.
- R3: On a reset other than power-on, the register reads exactly one set flag. The flag bit positions are: pin 0, supply monitor 1, lost clock 2, watchdog 3, software 4, comparator 5, flash error 6.
- R4: When several requests are active on the same edge, the lowest flag position wins. Pin comes first, then supply monitor, lost clock, watchdog, software, comparator, and flash error last.
- R5: A write with bit 4 set triggers a reset on the second edge after the write edge, and the register then reads 0x10. A write with bit 4 clear triggers nothing.
- R6: Write bit 5 is the comparator enable. When it is 1, a comparator output of 0 causes a reset. When it is 0, the comparator has no effect.
- R7: Write bit 2 sets the clock-detector enable output. A lost-clock event causes a reset only while that enable is 1.
- R8: Write bit 1 sets the supply-monitor enable output. A supply trip causes a reset only while that enable is 1.
- R9: Bit 7 always reads 0. Writes to bits 7, 6, 3 and 0 leave the cause flags unchanged.
- R10: Writes made while the system reset is high are ignored.
- R11: The comparator, clock-detector and supply-monitor enables keep their values through every reset except power-on.
- R12: Read data is 0 unless the read strobe is high and the address is 0xEF.
- R13: The cause is captured only when a reset begins. A request that arrives during a reset already in progress extends the reset but does not change the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| por_i | input | 1 | Power-on reset, asynchronous, active high |
| pin_rst_i | input | 1 | External reset pin request, active high |
| supply_low_i | input | 1 | Supply monitor trip |
| clk_lost_i | input | 1 | Missing-clock event |
| wdog_expire_i | input | 1 | Watchdog timeout |
| cmp_out_i | input | 1 | Comparator output, requests reset when low |
| flash_err_i | input | 1 | Flash access error |
| sfr_addr_i | input | 8 | Register bus address |
| sfr_wr_i | input | 1 | Write strobe |
| sfr_rd_i | input | 1 | Read strobe |
| sfr_wdata_i | input | 8 | Write data |
| sfr_rdata_o | output | 8 | Read data |
| sys_rst_o | output | 1 | Stretched system reset |
| supply_mon_en_o | output | 1 | Supply monitor enable |
| clk_det_en_o | output | 1 | Missing-clock detector enable |

## Verification
The assertions assume that every clocked input is synchronous to the clock and never unknown once power-on has been asserted. Power-on is the only asynchronous input. The properties are disabled while power-on is high. The stimulus changes every input on the falling clock edge and holds each request for one whole cycle. It raises and drops power-on away from the rising edge, and it keeps the comparator output high whenever no comparator request is intended, so an enabled comparator never fires by accident.

// File: rtl/rcc_pkg.sv
package rcc_pkg;
   localparam int unsigned NUM_CAUSES = 7;

   // Flag positions double as priority: lower index wins.
   typedef enum int unsigned {
      CAUSE_PIN     = 0,
      CAUSE_SUPPLY  = 1,
      CAUSE_CLKLOSS = 2,
      CAUSE_WDOG    = 3,
      CAUSE_SWREQ   = 4,
      CAUSE_CMP     = 5,
      CAUSE_FLASH   = 6
   } cause_e;
endpackage

// File: rtl/rcc_prio_pick.sv
module rcc_prio_pick #(
   parameter int unsigned N = 7
) (
   input  logic [N-1:0] req_i,
   output logic [N-1:0] grant_o,
   output logic         any_o
);
   logic [N-1:0] blocked;

   for (genvar i = 0; i < N; i++) begin : g_stage
      if (i == 0) begin : g_first
         assign blocked[i] = 1'b0;
      end else begin : g_rest
         assign blocked[i] = blocked[i-1] | req_i[i-1];
      end
      assign grant_o[i] = req_i[i] & ~blocked[i];
   end

   assign any_o = |req_i;

   always_comb begin
      if (!$isunknown(req_i)) begin
         assert_single_winner_R4: assert ($onehot0(grant_o) && (any_o == (grant_o != '0)))
            else $error("priority pick produced %b for %b", grant_o, req_i);
      end
   end
endmodule

// File: rtl/rcc_stretch.sv
module rcc_stretch #(
   parameter int unsigned STRETCH_CYCLES = 16
) (
   input  logic clk_i,
   input  logic por_i,
   input  logic req_i,
   output logic active_o
);
   localparam int unsigned CNT_W = $clog2(STRETCH_CYCLES);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(STRETCH_CYCLES - 1);

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk_i or posedge por_i) begin
      if (por_i) begin
         active_o <= 1'b1;
         cnt      <= '0;
      end else if (req_i) begin
         active_o <= 1'b1;
         cnt      <= '0;
      end else if (active_o) begin
         if (cnt == LAST) begin
            active_o <= 1'b0;
         end else begin
            cnt <= cnt + 1'b1;
         end
      end
   end

   // Independent quiet-window counter for the release checks.
   logic [CNT_W:0] quiet_cnt;
   always_ff @(posedge clk_i or posedge por_i) begin
      if (por_i) begin
         quiet_cnt <= '0;
      end else if (req_i || !active_o) begin
         quiet_cnt <= '0;
      end else begin
         quiet_cnt <= quiet_cnt + 1'b1;
      end
   end

   assert_req_holds_reset_R2: assert property (@(posedge clk_i) disable iff (por_i)
      req_i |=> active_o);
   assert_release_after_full_window_R2: assert property (@(posedge clk_i) disable iff (por_i)
      $fell(active_o) |-> (quiet_cnt == (CNT_W+1)'(STRETCH_CYCLES)));
   assert_window_not_exceeded_R2: assert property (@(posedge clk_i) disable iff (por_i)
      active_o |-> (quiet_cnt < (CNT_W+1)'(STRETCH_CYCLES)));
endmodule

// File: rtl/rcc_regs.sv
module rcc_regs import rcc_pkg::*; #(
   parameter int unsigned DATA_W   = 8,
   parameter int unsigned ADDR_W   = 8,
   parameter logic [ADDR_W-1:0] SFR_ADDR = 8'hEF
) (
   input  logic                  clk_i,
   input  logic                  por_i,
   input  logic                  rst_active_i,
   input  logic                  capture_i,
   input  logic [NUM_CAUSES-1:0] grant_i,
   input  logic [ADDR_W-1:0]     sfr_addr_i,
   input  logic                  sfr_wr_i,
   input  logic                  sfr_rd_i,
   input  logic [DATA_W-1:0]     sfr_wdata_i,
   output logic [DATA_W-1:0]     sfr_rdata_o,
   output logic                  cmp_en_o,
   output logic                  mcd_en_o,
   output logic                  sup_en_o,
   output logic                  sw_req_o
);
   localparam logic [NUM_CAUSES-1:0] POR_FLAGS = NUM_CAUSES'(1) << CAUSE_SUPPLY;

   logic [NUM_CAUSES-1:0] flags;
   logic wr_hit, wr_ok, rd_hit;

   assign wr_hit = sfr_wr_i && (sfr_addr_i == SFR_ADDR);
   assign wr_ok  = wr_hit && !rst_active_i;
   assign rd_hit = sfr_rd_i && (sfr_addr_i == SFR_ADDR);

   always_ff @(posedge clk_i or posedge por_i) begin
      if (por_i) begin
         flags <= POR_FLAGS;
      end else if (capture_i) begin
         flags <= grant_i;
      end
   end

   always_ff @(posedge clk_i or posedge por_i) begin
      if (por_i) begin
         cmp_en_o <= 1'b0;
         mcd_en_o <= 1'b0;
         sup_en_o <= 1'b1;
         sw_req_o <= 1'b0;
      end else begin
         sw_req_o <= wr_ok && sfr_wdata_i[CAUSE_SWREQ];
         if (wr_ok) begin
            cmp_en_o <= sfr_wdata_i[CAUSE_CMP];
            mcd_en_o <= sfr_wdata_i[CAUSE_CLKLOSS];
            sup_en_o <= sfr_wdata_i[CAUSE_SUPPLY];
         end
      end
   end

   assign sfr_rdata_o = rd_hit ? DATA_W'(flags) : '0;

   always_comb begin
      if (!$isunknown(sfr_rdata_o)) begin
         assert_top_bit_reads_zero_R9: assert (sfr_rdata_o[DATA_W-1] == 1'b0)
            else $error("bit 7 of read data is set");
      end
   end

   assert_flags_hold_R13: assert property (@(posedge clk_i) disable iff (por_i)
      !capture_i |=> $stable(flags));
   assert_one_cause_R3: assert property (@(posedge clk_i) disable iff (por_i)
      capture_i |=> $onehot(flags));
   assert_blocked_write_R10: assert property (@(posedge clk_i) disable iff (por_i)
      (rst_active_i && wr_hit) |=> $stable({cmp_en_o, mcd_en_o, sup_en_o}));
   assert_sw_trigger_R5: assert property (@(posedge clk_i) disable iff (por_i)
      (wr_ok && sfr_wdata_i[CAUSE_SWREQ]) |=> ##1 rst_active_i);
endmodule

// File: rtl/rst_cause_ctrl.sv
module rst_cause_ctrl import rcc_pkg::*; #(
   parameter int unsigned DATA_W          = 8,
   parameter int unsigned ADDR_W          = 8,
   parameter logic [ADDR_W-1:0] SFR_ADDR  = 8'hEF,
   parameter int unsigned STRETCH_CYCLES  = 16,
   parameter int unsigned PIN_SYNC_STAGES = 0
) (
   input  logic              clk_i,
   input  logic              por_i,
   input  logic              pin_rst_i,
   input  logic              supply_low_i,
   input  logic              clk_lost_i,
   input  logic              wdog_expire_i,
   input  logic              cmp_out_i,
   input  logic              flash_err_i,
   input  logic [ADDR_W-1:0] sfr_addr_i,
   input  logic              sfr_wr_i,
   input  logic              sfr_rd_i,
   input  logic [DATA_W-1:0] sfr_wdata_i,
   output logic [DATA_W-1:0] sfr_rdata_o,
   output logic              sys_rst_o,
   output logic              supply_mon_en_o,
   output logic              clk_det_en_o
);
   if (DATA_W <= NUM_CAUSES) begin : g_bad_width
      $error("DATA_W must leave an unused top bit above the cause flags");
   end
   if (STRETCH_CYCLES < 2) begin : g_bad_stretch
      $error("STRETCH_CYCLES must be at least 2");
   end

   logic pin_q;
   if (PIN_SYNC_STAGES == 0) begin : g_pin_direct
      assign pin_q = pin_rst_i;
   end else begin : g_pin_sync
      logic [PIN_SYNC_STAGES-1:0] sync_q;
      always_ff @(posedge clk_i or posedge por_i) begin
         if (por_i) begin
            sync_q <= '0;
         end else begin
            sync_q <= {sync_q[PIN_SYNC_STAGES-1:0] , pin_rst_i} >> 0 == '0 ? '0 : PIN_SYNC_STAGES'({sync_q, pin_rst_i});
         end
      end
      assign pin_q = sync_q[PIN_SYNC_STAGES-1];
   end

   logic [NUM_CAUSES-1:0] req_vec, grant_vec;
   logic any_req, rst_active, capture;
   logic cmp_en, mcd_en, sup_en, sw_req;

   always_comb begin
      req_vec                = '0;
      req_vec[CAUSE_PIN]     = pin_q;
      req_vec[CAUSE_SUPPLY]  = supply_low_i & sup_en;
      req_vec[CAUSE_CLKLOSS] = clk_lost_i & mcd_en;
      req_vec[CAUSE_WDOG]    = wdog_expire_i;
      req_vec[CAUSE_SWREQ]   = sw_req;
      req_vec[CAUSE_CMP]     = ~cmp_out_i & cmp_en;
      req_vec[CAUSE_FLASH]   = flash_err_i;
   end

   rcc_prio_pick #(.N(NUM_CAUSES)) u_pick (
      .req_i   (req_vec),
      .grant_o (grant_vec),
      .any_o   (any_req)
   );

   rcc_stretch #(.STRETCH_CYCLES(STRETCH_CYCLES)) u_stretch (
      .clk_i    (clk_i),
      .por_i    (por_i),
      .req_i    (any_req),
      .active_o (rst_active)
   );

   assign capture = any_req & ~rst_active;

   rcc_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .SFR_ADDR(SFR_ADDR)) u_regs (
      .clk_i        (clk_i),
      .por_i        (por_i),
      .rst_active_i (rst_active),
      .capture_i    (capture),
      .grant_i      (grant_vec),
      .sfr_addr_i   (sfr_addr_i),
      .sfr_wr_i     (sfr_wr_i),
      .sfr_rd_i     (sfr_rd_i),
      .sfr_wdata_i  (sfr_wdata_i),
      .sfr_rdata_o  (sfr_rdata_o),
      .cmp_en_o     (cmp_en),
      .mcd_en_o     (mcd_en),
      .sup_en_o     (sup_en),
      .sw_req_o     (sw_req)
   );

   assign sys_rst_o       = rst_active;
   assign supply_mon_en_o = sup_en;
   assign clk_det_en_o    = mcd_en;

   assert_gated_clock_R7: assert property (@(posedge clk_i) disable iff (por_i)
      (!rst_active && clk_lost_i && !mcd_en && !pin_q && !(supply_low_i && sup_en) &&
       !wdog_expire_i && !sw_req && !(!cmp_out_i && cmp_en) && !flash_err_i) |=> !rst_active);
   assert_por_defaults_R1: assert property (@(posedge clk_i)
      por_i |-> (rst_active && sup_en && !mcd_en && !cmp_en));
endmodule

// File: tb/rst_cause_ctrl_test.sv
module rst_cause_ctrl_test;
   localparam time CLK_PERIOD = 10ns;
   localparam logic [7:0] REG_ADDR = 8'hEF;

   logic clk = 1'b0;
   logic por, pin, sup_low, clk_lost, wdog, cmp_out, flash;
   logic [7:0] addr, wdata;
   logic wr, rd;
   logic [7:0] rdata;
   logic sys_rst, sup_en, det_en;

   int n_vec = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   rst_cause_ctrl uut (
      .clk_i (clk), .por_i (por), .pin_rst_i (pin), .supply_low_i (sup_low),
      .clk_lost_i (clk_lost), .wdog_expire_i (wdog), .cmp_out_i (cmp_out),
      .flash_err_i (flash), .sfr_addr_i (addr), .sfr_wr_i (wr), .sfr_rd_i (rd),
      .sfr_wdata_i (wdata), .sfr_rdata_o (rdata), .sys_rst_o (sys_rst),
      .supply_mon_en_o (sup_en), .clk_det_en_o (det_en)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   // mask bit positions follow the flag layout of R3
   task automatic pulse(input logic [6:0] m);
      @(negedge clk);
      pin = m[0]; sup_low = m[1]; clk_lost = m[2]; wdog = m[3];
      cmp_out = ~m[5]; flash = m[6];
      @(negedge clk);
      pin = 0; sup_low = 0; clk_lost = 0; wdog = 0; cmp_out = 1; flash = 0;
   endtask

   task automatic write_reg(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      addr = a; wdata = d; wr = 1;
      @(negedge clk);
      wr = 0; wdata = 0;
   endtask

   task automatic read_reg(input logic [7:0] a, input logic strobe, output logic [7:0] v);
      addr = a; rd = strobe;
      #1 v = rdata;
      rd = 0;
   endtask

   // called at the falling edge right after the last request edge
   task automatic expect_release(input string tag);
      repeat (15) @(posedge clk);
      @(negedge clk);
      check({tag, " high on 15th edge"}, sys_rst, 1);
      @(posedge clk);
      @(negedge clk);
      check({tag, " low after 16th edge"}, sys_rst, 0);
   endtask

   task automatic wait_low();
      for (int i = 0; i < 40 && sys_rst; i++) @(negedge clk);
   endtask

   task automatic cause_case(input string tag, input logic [6:0] m, input logic [7:0] exp);
      logic [7:0] v;
      pulse(m);
      check({tag, " reset taken"}, sys_rst, 1);
      read_reg(REG_ADDR, 1, v);
      check({tag, " flags"}, v, exp);
      expect_release(tag);
   endtask

   task automatic t_por_defaults();
      logic [7:0] v;
      check("R1 reset during power-on", sys_rst, 1);
      read_reg(REG_ADDR, 1, v);
      check("R1 flags", v, 8'h02);
      check("R1 supply enable", sup_en, 1);
      check("R1 detector enable", det_en, 0);
      @(negedge clk); por = 0;
      expect_release("R2 after power-on");
      pulse(7'h20);
      check("R1 comparator disabled", sys_rst, 0);
   endtask

   task automatic t_single_causes();
      cause_case("R3 pin", 7'h01, 8'h01);
      cause_case("R3 watchdog", 7'h08, 8'h08);
      cause_case("R3 flash", 7'h40, 8'h40);
      cause_case("R8 supply enabled", 7'h02, 8'h02);
   endtask

   task automatic t_supply_gate();
      logic [7:0] v;
      write_reg(REG_ADDR, 8'h00);
      check("R8 supply enable cleared", sup_en, 0);
      pulse(7'h02);
      check("R8 supply trip ignored", sys_rst, 0);
      read_reg(REG_ADDR, 1, v);
      check("R8 flags untouched", v, 8'h02);
   endtask

   task automatic t_clock_detector();
      write_reg(REG_ADDR, 8'h04);
      check("R7 detector enable set", det_en, 1);
      cause_case("R7 lost clock", 7'h04, 8'h04);
      write_reg(REG_ADDR, 8'h00);
      check("R7 detector enable cleared", det_en, 0);
      pulse(7'h04);
      check("R7 lost clock ignored", sys_rst, 0);
   endtask

   task automatic t_comparator();
      write_reg(REG_ADDR, 8'h20);
      cause_case("R6 comparator", 7'h20, 8'h20);
      write_reg(REG_ADDR, 8'h00);
      pulse(7'h20);
      check("R6 comparator disabled", sys_rst, 0);
   endtask

   task automatic t_enables_kept();
      write_reg(REG_ADDR, 8'h26);
      pulse(7'h01);
      check("R11 detector kept", det_en, 1);
      check("R11 supply kept", sup_en, 1);
      expect_release("R11 pin");
      cause_case("R11 comparator kept", 7'h20, 8'h20);
   endtask

   task automatic t_blocked_write();
      pulse(7'h01);
      write_reg(REG_ADDR, 8'h00);
      check("R10 detector after blocked write", det_en, 1);
      check("R10 supply after blocked write", sup_en, 1);
      wait_low();
      @(negedge clk);
      check("R10 no trigger from blocked write", sys_rst, 0);
   endtask

   task automatic t_software();
      logic [7:0] v;
      write_reg(REG_ADDR, 8'h06);
      check("R5 zero bit 4 no reset", sys_rst, 0);
      @(negedge clk);
      check("R5 zero bit 4 still none", sys_rst, 0);
      write_reg(REG_ADDR, 8'h16);
      check("R5 not yet after write edge", sys_rst, 0);
      @(negedge clk);
      check("R5 software reset", sys_rst, 1);
      read_reg(REG_ADDR, 1, v);
      check("R5 flags", v, 8'h10);
      expect_release("R5");
   endtask

   task automatic t_priority();
      cause_case("R4 pin over flash", 7'h41, 8'h01);
      cause_case("R4 watchdog over flash", 7'h48, 8'h08);
      cause_case("R4 supply over watchdog", 7'h0A, 8'h02);
      write_reg(REG_ADDR, 8'h26);
      cause_case("R4 comparator over flash", 7'h60, 8'h20);
      cause_case("R4 clock over watchdog and comparator", 7'h2C, 8'h04);
   endtask

   task automatic t_readonly_bits();
      logic [7:0] v;
      write_reg(REG_ADDR, 8'hC9);
      check("R9 no reset from write", sys_rst, 0);
      read_reg(REG_ADDR, 1, v);
      check("R9 flags unchanged and bit 7 zero", v, 8'h04);
      check("R9 enables follow write", {sup_en, det_en}, 2'b00);
   endtask

   task automatic t_capture_once();
      logic [7:0] v;
      pulse(7'h01);
      pulse(7'h40);
      check("R13 reset still high", sys_rst, 1);
      read_reg(REG_ADDR, 1, v);
      check("R13 first cause kept", v, 8'h01);
      expect_release("R13 extended");
   endtask

   task automatic t_read_decode();
      logic [7:0] v;
      read_reg(8'hEE, 1, v);
      check("R12 other address", v, 8'h00);
      read_reg(REG_ADDR, 0, v);
      check("R12 no strobe", v, 8'h00);
   endtask

   task automatic t_por_again();
      logic [7:0] v;
      write_reg(REG_ADDR, 8'h24);
      @(negedge clk);
      #2 por = 1;
      #1;
      check("R1 async assert", sys_rst, 1);
      read_reg(REG_ADDR, 1, v);
      check("R1 flags after second power-on", v, 8'h02);
      check("R1 enables after second power-on", {sup_en, det_en}, 2'b10);
      @(negedge clk); por = 0;
      expect_release("R2 second power-on");
      pulse(7'h20);
      check("R1 comparator cleared by power-on", sys_rst, 0);
   endtask

   initial begin
      por = 1; pin = 0; sup_low = 0; clk_lost = 0; wdog = 0; cmp_out = 1; flash = 0;
      addr = 0; wdata = 0; wr = 0; rd = 0;
      repeat (3) @(negedge clk);
      t_por_defaults();
      t_single_causes();
      t_supply_gate();
      t_clock_detector();
      t_comparator();
      t_enables_kept();
      t_blocked_write();
      t_software();
      t_priority();
      t_readonly_bits();
      t_capture_once();
      t_read_decode();
      t_por_again();
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_vec++;
         n_bad++;
         $display("FAIL watchdog: actual hung expected done");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end
endmodule